// File: doc/BRIEF.md
# Frame Slip Elastic Store

This block sits between an incoming stream of E1 timeslot bytes and an outgoing one whose long-term rates differ slightly. Both sides share one clock. The writer presents a byte with a write strobe, and the reader requests a byte with a read strobe. A circular store holds two frames of 32 byte-wide timeslots. The store absorbs the drift between the two sides. When the drift exceeds that margin, the block makes a controlled slip of exactly one whole frame, so the frame alignment downstream is kept.

A write that finds the store full discards the oldest complete frame to make room. A read that finds the store empty replays the most recently read complete frame, starting from its first timeslot. Each kind of slip is latched into a sticky flag of an 8-bit status word. A shared flag marks that a slip of either kind occurred. Software clears the flags by reading the status word, or by writing ones to the flag positions.

Top module: `frame_slip_store`

## Requirements
- R1: After reset the status word is 0x00, and the store holds one frame of 32 zero bytes, so that the first 32 reads return 0x00.
- R2: Without slips, bytes come out in the order they were written. The byte for a read request appears on `rdData` on the clock edge that samples `rdEn`, and holds until the next read.
- R3: A write with no read in the same cycle, arriving while the store holds 64 bytes, discards the 32 oldest stored bytes and then stores the new byte, leaving 33 bytes.
- R4: A read arriving while the store is empty replays the 32 most recently read bytes, oldest first, and returns the first of them.
- R5: Status bit 7 (full slip) is set by an R3 deletion, and bit 6 (empty slip) is set by an R4 repetition. Bit 5 (slip) is set by either event. Bits 4..0 always read 0.
- R6: A pulse on `statRd` clears bits 7..5 at the following clock edge.
- R7: A pulse on `statWr` clears each of bits 7..5 whose bit in `statWrData` is 1, and leaves the other flags unchanged.
- R8: If a slip event and a clear happen in the same cycle, the flags set by that event remain 1.
- R9: A read and a write in the same cycle while the store is full cause no slip and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for writer, reader and host |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for `wrData` |
| wrData | input | 8 | Incoming timeslot byte |
| rdEn | input | 1 | Read request strobe |
| rdData | output | 8 | Outgoing timeslot byte, registered |
| statRd | input | 1 | Host read of the status word (clear on read) |
| statWr | input | 1 | Host write strobe for the status word |
| statWrData | input | 8 | Host write data; ones in bits 7..5 clear those flags |
| status | output | 8 | Sticky slip flags: bit 7 full, bit 6 empty, bit 5 slip |

## Verification
If the occupancy count drifts from the true pointer distance, a slip fires at the wrong moment. The next status word shows a flag where none was due, and the output stream shows a 32-byte jump or repeat at the wrong place. A read pointer that is displaced by a deletion or repetition of the wrong size shows up on the very first byte after the slip, because the scoreboard expects an exact frame boundary. A flag-clearing fault shows up on the cycle after the host access.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef struct packed {
    logic write;
    logic read;
    logic dropFrame;
    logic replayFrame;
  } fssStrobes_t;

  localparam int unsigned FULL_BIT  = 7;
  localparam int unsigned EMPTY_BIT = 6;
  localparam int unsigned SLIP_BIT  = 5;
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned FRAMES = 2,
  localparam int unsigned DEPTH = SLOTS * FRAMES,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  output fssStrobes_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [CW-1:0] level
);
  localparam logic [AW-1:0] FRAME_A = AW'(SLOTS);
  localparam logic [CW-1:0] FRAME_C = CW'(SLOTS);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;
  logic          isFull, isEmpty;

  assign isFull  = (cnt == DEPTH_C);
  assign isEmpty = (cnt == '0);

  always_comb begin
    stb.write       = wrEn;
    stb.read        = rdEn;
    stb.dropFrame   = wrEn && !rdEn && isFull;
    stb.replayFrame = rdEn && isEmpty;
  end

  assign wrAddr = wrPtr;
  assign rdAddr = stb.replayFrame ? rdPtr - FRAME_A : rdPtr;
  assign level  = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= FRAME_A;
      rdPtr <= '0;
      cnt   <= FRAME_C;
    end else begin
      if (wrEn) wrPtr <= wrPtr + 1'b1;
      if (rdEn)               rdPtr <= rdAddr + 1'b1;
      else if (stb.dropFrame) rdPtr <= rdPtr + FRAME_A;
      cnt <= cnt
           + (stb.replayFrame ? FRAME_C : '0)
           - (stb.dropFrame   ? FRAME_C : '0)
           + CW'(wrEn) - CW'(rdEn);
    end
  end
endmodule

// File: rtl/fss_datapath.sv
module fss_datapath
  import fss_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fssStrobes_t   stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      rdData <= '0;
    end else begin
      if (stb.write) store[wrAddr] <= wrData;
      if (stb.read)  rdData <= store[rdAddr];
    end
  end
endmodule

// File: rtl/fss_status.sv
module fss_status
  import fss_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  fssStrobes_t stb,
  input  logic        statRd,
  input  logic        statWr,
  input  logic [7:0]  statWrData,
  output logic [7:0]  status
);
  logic fullF, emptyF, slipF;
  logic clrFull, clrEmpty, clrSlip;

  assign clrFull  = statRd || (statWr && statWrData[FULL_BIT]);
  assign clrEmpty = statRd || (statWr && statWrData[EMPTY_BIT]);
  assign clrSlip  = statRd || (statWr && statWrData[SLIP_BIT]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullF  <= 1'b0;
      emptyF <= 1'b0;
      slipF  <= 1'b0;
    end else begin
      fullF  <= (fullF  && !clrFull)  || stb.dropFrame;
      emptyF <= (emptyF && !clrEmpty) || stb.replayFrame;
      slipF  <= (slipF  && !clrSlip)  || stb.dropFrame || stb.replayFrame;
    end
  end

  always_comb begin
    status = '0;
    status[FULL_BIT]  = fullF;
    status[EMPTY_BIT] = emptyF;
    status[SLIP_BIT]  = slipF;
  end
endmodule

// File: rtl/frame_slip_store.sv
module frame_slip_store
  import fss_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned FRAMES = 2,
  localparam int unsigned DEPTH = SLOTS * FRAMES,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  input  logic          statRd,
  input  logic          statWr,
  input  logic [7:0]    statWrData,
  output logic [7:0]    status
);
  fssStrobes_t   stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [CW-1:0] level;

  fss_ctrl #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .level(level)
  );

  fss_datapath #(.DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

  fss_status u_stat (
    .clk(clk), .rstN(rstN), .stb(stb), .statRd(statRd), .statWr(statWr),
    .statWrData(statWrData), .status(status)
  );
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int unsigned CW    = 7,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned SLOTS = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          rdEn,
  input logic          statRd,
  input logic [7:0]    status,
  input logic [CW-1:0] level
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    level <= CW'(DEPTH));

  assert_drop_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && level == CW'(DEPTH)) |=> (level == CW'(DEPTH - SLOTS + 1)));

  assert_full_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && level == CW'(DEPTH)) |=> (status[7] && status[5]));

  assert_empty_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && level == '0) |=> (status[6] && status[5]));

  assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    status[4:0] == 5'd0);

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !(rdEn && level == '0) && !(wrEn && !rdEn && level == CW'(DEPTH)))
      |=> (status[7:5] == 3'b000));

  assert_no_slip_both_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && level == CW'(DEPTH) && !statRd) |=> $stable(status));
endmodule

bind frame_slip_store fss_checker #(.CW(CW), .DEPTH(DEPTH), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .statRd(statRd),
  .status(status), .level(level)
);

// File: tb/frame_slip_store_tb.sv
module frame_slip_store_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, statRd = 1'b0, statWr = 1'b0;
  logic [7:0] wrData = '0, statWrData = '0;
  logic [7:0] rdData, status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  byte unsigned modelQ[$];
  byte unsigned hist[$];
  byte unsigned expQ[$];
  string        expTag[$];

  always #5 clk = ~clk;

  frame_slip_store u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .statRd(statRd), .statWr(statWr),
    .statWrData(statWrData), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver: called at a negedge; applies one cycle of stimulus and updates the model.
  task automatic doOp(input bit wr, input byte unsigned wd, input bit rd,
                      input bit sRd, input string tag);
    bit wasFull;
    wasFull = (modelQ.size() == 64);
    wrEn = wr; wrData = wd; rdEn = rd; statRd = sRd;
    if (rd) begin
      byte unsigned b;
      if (modelQ.size() == 0) modelQ = hist;
      b = modelQ.pop_front();
      hist.push_back(b);
      void'(hist.pop_front());
      expQ.push_back(b);
      expTag.push_back(tag);
    end
    if (wr) begin
      if (wasFull && !rd) for (int i = 0; i < 32; i++) void'(modelQ.pop_front());
      modelQ.push_back(wd);
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; statRd = 1'b0;
  endtask

  task automatic hostWrite(input byte unsigned d);
    statWr = 1'b1; statWrData = d;
    @(negedge clk);
    statWr = 1'b0; statWrData = '0;
  endtask

  // Monitor: pops expected bytes when the design produces read results.
  initial begin
    forever begin
      bit pend;
      @(posedge clk);
      pend = rdEn;
      @(negedge clk);
      if (pend) begin
        if (expQ.size() == 0) check("R2 unexpected read", 1, 0);
        else begin
          string t;
          byte unsigned e;
          e = expQ.pop_front();
          t = expTag.pop_front();
          check(t, int'(rdData), int'(e));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin modelQ.push_back(8'h00); hist.push_back(8'h00); end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset status", int'(status), 8'h00);

    doOp(0, 0, 1, 0, "R1 initial zero frame");
    for (int i = 0; i < 33; i++) doOp(1, byte'(8'h40 + i), 0, 0, "R2 fill");
    check("R9 no slip on reaching full", int'(status), 8'h00);

    doOp(1, 8'hB0, 0, 0, "R3 write on full");
    check("R5 full+slip after deletion", int'(status), 8'hA0);
    doOp(0, 0, 0, 1, "R6 status read");
    check("R6 cleared by read", int'(status), 8'h00);

    for (int i = 0; i < 33; i++) doOp(0, 0, 1, 0, "R3 order after deletion");
    check("R2 no slip draining", int'(status), 8'h00);

    doOp(0, 0, 1, 0, "R4 replay first byte");
    check("R5 empty+slip after repeat", int'(status), 8'h60);
    for (int i = 0; i < 31; i++) doOp(0, 0, 1, 0, "R4 replayed frame");

    hostWrite(8'h5F);
    check("R7 clear only bit 6", int'(status), 8'h20);
    hostWrite(8'h80);
    check("R7 bit 7 clear leaves slip", int'(status), 8'h20);
    hostWrite(8'h20);
    check("R7 clear bit 5", int'(status), 8'h00);

    doOp(0, 0, 1, 1, "R8 repeat with status read");
    check("R8 set wins over clear", int'(status), 8'h60);
    doOp(0, 0, 0, 1, "R6 clear");
    check("R6 cleared again", int'(status), 8'h00);

    for (int i = 0; i < 33; i++) doOp(1, byte'(8'hC0 + i), 0, 0, "R2 refill");
    check("R2 full without slip", int'(status), 8'h00);
    doOp(1, 8'hEE, 1, 0, "R9 read on full with write");
    check("R9 no slip with simultaneous access", int'(status), 8'h00);
    for (int i = 0; i < 64; i++) doOp(0, 0, 1, 0, "R9 order after simultaneous");
    check("R9 drained without slip", int'(status), 8'h00);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule